// File: doc/BRIEF.md
# Paged Tag Record Decoder

The decoder takes a byte stream of configuration data stored as a chain of memory-page packets. Every packet starts with a byte count, carries that many payload bytes, and closes with a 16-bit check word. The decoder verifies each packet's check word and drops the framing. It then reads the joined payloads as one continuous stream of tag records. Each record is a tag number byte, a value length byte and the value bytes. A record may begin in one packet and end in a later one.

For every value byte the decoder reports the tag, the record length, the byte's position within the value and the byte itself. When a record completes, it raises an end pulse. For values of one to four bytes it also delivers a numeric word, built with the first stored byte in the least significant position. A start pulse begins a decode, and a done flag, together with two sticky error flags, reports how the decode ended.

Top module: `tagdec_top`

## Requirements
- R1: After reset all outputs are 0, including `done`, `crc_err` and `fmt_err`.
- R2: Each packet is checked with a CRC-16 over its count byte and payload: polynomial x^16+x^15+x^2+1, processed least significant bit first, zero seed. The stored word is the bitwise inverse of the result, sent low byte first. A packet that matches lets decoding continue with the next count byte.
- R3: On a check word mismatch, `crc_err` and `done` go high in the cycle after the second check byte. No `val_valid` or `rec_end` pulse follows, even though value bytes of the failing packet were already reported.
- R4: A count byte of 00h or FFh ends decoding cleanly: `done` goes high and both error flags stay low.
- R5: A count byte from 30 to 254 does not fit a 32-byte page. It sets `fmt_err` and `done`, and no byte of that packet is reported.
- R6: Payload records are parsed as tag byte, length byte, then value bytes. One cycle after each accepted value byte, `val_valid` is high with `val_byte`, `rec_tag`, `rec_len` and a 0-based `val_idx`.
- R7: Parser state carries across packet boundaries, so a record split over several packets is reported the same as an unsplit one.
- R8: `rec_end` pulses together with the last value byte of a record. For a zero-length record it pulses one cycle after the length byte. For lengths 1 to 4, `num_valid` pulses with it, and `num_value` holds value byte k at bits 8k+7:8k with all higher bits zero.
- R9: For records of length 0 or longer than 4, `num_valid` stays low and `num_value` is 0. The value bytes are still reported in stored order.
- R10: Bytes count only in cycles where `in_valid` is high. A `start` pulse clears the flags and restarts at a count byte with an empty record state, even in the middle of a decode.
- R11: Once `done` is high it stays high until the next `start`, and further input bytes produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new decode |
| in_valid | input | 1 | `in_byte` holds a stream byte |
| in_byte | input | 8 | Stream byte |
| val_valid | output | 1 | A value byte is reported |
| val_byte | output | 8 | Value byte |
| val_idx | output | 8 | Position of the byte inside its value |
| rec_tag | output | 8 | Tag number of the current record |
| rec_len | output | 8 | Value length of the current record |
| rec_end | output | 1 | Record finished this cycle |
| num_valid | output | 1 | `num_value` is meaningful (length 1 to 4) |
| num_value | output | 32 | Little-endian assembled value |
| crc_err | output | 1 | A packet failed its check word |
| fmt_err | output | 1 | A packet count did not fit a page |
| done | output | 1 | Decoding has ended |

## Verification
The bench aims at records that straddle packet boundaries, including a 35-byte record split over full 29-byte pages. A design that reset its parser at each packet would misreport the tail as new tags. It drives lengths of 0, 4 and 5, where a wrong size bound would assert or drop `num_valid`, and a byte-order mix-up would turn 080000h into 000008h. Corrupted check words, out-of-range counts (30 and higher) and both clean terminators are each used to end decoding. A restart in the middle of a packet checks that no stale record state leaks into the next decode. Bytes sent after `done` check that a design which kept parsing after a failure would be caught.

// File: rtl/tagdec_pkg.sv
// Shared types and the check-word step function for the tag decoder.
package tagdec_pkg;

    typedef enum logic [2:0] {
        FR_IDLE, FR_LEN, FR_PAY, FR_CRCL, FR_CRCH, FR_STOP
    } fr_state_t;

    typedef enum logic [1:0] {
        PS_TAG, PS_LEN, PS_VAL
    } ps_state_t;

    // One byte of the reflected x^16+x^15+x^2+1 CRC, LSB first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic [7:0]  x;
        r = c;
        x = d;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ x[0]) == 1'b1) r = (r >> 1) ^ 16'hA001;
            else                       r = r >> 1;
            x = x >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/tagdec_framer.sv
// Packet framer: reads count byte, payload and check word per packet,
// forwards payload bytes combinationally and records how decoding ends.
// Assumes the stream begins with a count byte after each start pulse.
module tagdec_framer #(
    parameter int PAGE_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       pay_valid,
    output logic [7:0] pay_byte,
    output logic       crc_err,
    output logic       fmt_err,
    output logic       done
);
    import tagdec_pkg::*;

    localparam logic [7:0] MAX_LEN = 8'(PAGE_BYTES - 3);

    fr_state_t   st;
    logic [7:0]  remain;
    logic [15:0] crc;
    logic [7:0]  crc_lo;

    // Payload bytes pass straight to the parser.
    always_comb begin
        pay_valid = in_valid && (st == FR_PAY);
        pay_byte  = in_byte;
    end

    // Packet sequencing, check-word accumulation and end flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FR_IDLE;
            remain  <= '0;
            crc     <= '0;
            crc_lo  <= '0;
            crc_err <= 1'b0;
            fmt_err <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            st      <= FR_LEN;
            crc     <= '0;
            crc_err <= 1'b0;
            fmt_err <= 1'b0;
            done    <= 1'b0;
        end else if (in_valid) begin
            case (st)
                FR_LEN: begin
                    if (in_byte == 8'h00 || in_byte == 8'hFF) begin
                        st   <= FR_STOP;
                        done <= 1'b1;
                    end else if (in_byte > MAX_LEN) begin
                        st      <= FR_STOP;
                        fmt_err <= 1'b1;
                        done    <= 1'b1;
                    end else begin
                        remain <= in_byte;
                        crc    <= crc16_step(16'h0000, in_byte);
                        st     <= FR_PAY;
                    end
                end
                FR_PAY: begin
                    crc    <= crc16_step(crc, in_byte);
                    remain <= remain - 8'd1;
                    if (remain == 8'd1) st <= FR_CRCL;
                end
                FR_CRCL: begin
                    crc_lo <= in_byte;
                    st     <= FR_CRCH;
                end
                FR_CRCH: begin
                    if ({in_byte, crc_lo} == ~crc) begin
                        st <= FR_LEN;
                    end else begin
                        st      <= FR_STOP;
                        crc_err <= 1'b1;
                        done    <= 1'b1;
                    end
                end
                default: st <= st;
            endcase
        end
    end

    AST_PAYLOAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FR_PAY) |-> (remain >= 8'd1 && remain <= MAX_LEN)); // R5
    AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crc_err, fmt_err})); // R3
    AST_ERROR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err || fmt_err) |-> done); // R3

endmodule

// File: rtl/tagdec_parser.sv
// Tag record parser: walks tag, length and value bytes of the joined
// payload, reports each value byte and assembles short values LSB first.
// Assumes pay_valid only for payload bytes; state persists across packets.
module tagdec_parser #(
    parameter int NUM_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   pay_valid,
    input  logic [7:0]             pay_byte,
    output logic                   val_valid,
    output logic [7:0]             val_byte,
    output logic [7:0]             val_idx,
    output logic [7:0]             rec_tag,
    output logic [7:0]             rec_len,
    output logic                   rec_end,
    output logic                   num_valid,
    output logic [8*NUM_BYTES-1:0] num_value
);
    import tagdec_pkg::*;

    localparam int         NUM_W   = 8 * NUM_BYTES;
    localparam logic [7:0] NUM_MAX = 8'(NUM_BYTES);

    ps_state_t        ps;
    logic [7:0]       cur_tag;
    logic [7:0]       cur_len;
    logic [7:0]       cnt;
    logic [NUM_W-1:0] acc;
    logic [NUM_W-1:0] acc_next;

    // Drop the incoming byte into its little-endian lane.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        assign acc_next[8*k +: 8] = (cnt == 8'(k)) ? pay_byte : acc[8*k +: 8];
    end

    // Record state machine and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps        <= PS_TAG;
            cur_tag   <= '0;
            cur_len   <= '0;
            cnt       <= '0;
            acc       <= '0;
            val_valid <= 1'b0;
            val_byte  <= '0;
            val_idx   <= '0;
            rec_tag   <= '0;
            rec_len   <= '0;
            rec_end   <= 1'b0;
            num_valid <= 1'b0;
            num_value <= '0;
        end else begin
            val_valid <= 1'b0;
            rec_end   <= 1'b0;
            num_valid <= 1'b0;
            if (start) begin
                ps  <= PS_TAG;
                cnt <= '0;
                acc <= '0;
            end else if (pay_valid) begin
                case (ps)
                    PS_TAG: begin
                        cur_tag <= pay_byte;
                        ps      <= PS_LEN;
                    end
                    PS_LEN: begin
                        cur_len <= pay_byte;
                        cnt     <= '0;
                        acc     <= '0;
                        if (pay_byte == 8'd0) begin
                            rec_tag   <= cur_tag;
                            rec_len   <= 8'd0;
                            rec_end   <= 1'b1;
                            num_value <= '0;
                            ps        <= PS_TAG;
                        end else begin
                            ps <= PS_VAL;
                        end
                    end
                    PS_VAL: begin
                        val_valid <= 1'b1;
                        val_byte  <= pay_byte;
                        val_idx   <= cnt;
                        rec_tag   <= cur_tag;
                        rec_len   <= cur_len;
                        if (cnt == cur_len - 8'd1) begin
                            rec_end   <= 1'b1;
                            num_valid <= (cur_len <= NUM_MAX);
                            num_value <= (cur_len <= NUM_MAX) ? acc_next : '0;
                            ps        <= PS_TAG;
                        end else begin
                            cnt <= cnt + 8'd1;
                            acc <= acc_next;
                        end
                    end
                    default: ps <= PS_TAG;
                endcase
            end
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        val_valid |-> (val_idx < rec_len)); // R6
    AST_NUM_SHORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        num_valid |-> (rec_end && rec_len >= 8'd1 && rec_len <= NUM_MAX)); // R8
    AST_LONG_NO_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_end && rec_len > NUM_MAX) |-> (!num_valid && num_value == '0)); // R9

endmodule

// File: rtl/tagdec_top.sv
// Top of the paged tag record decoder: framer feeding the record parser.
// Assumes one stream byte per in_valid cycle and a start pulse per decode.
module tagdec_top #(
    parameter int PAGE_BYTES = 32,
    parameter int NUM_BYTES  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    output logic                   val_valid,
    output logic [7:0]             val_byte,
    output logic [7:0]             val_idx,
    output logic [7:0]             rec_tag,
    output logic [7:0]             rec_len,
    output logic                   rec_end,
    output logic                   num_valid,
    output logic [8*NUM_BYTES-1:0] num_value,
    output logic                   crc_err,
    output logic                   fmt_err,
    output logic                   done
);
    logic       pay_valid;
    logic [7:0] pay_byte;

    tagdec_framer #(.PAGE_BYTES(PAGE_BYTES)) u_framer (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_byte(in_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte),
        .crc_err(crc_err), .fmt_err(fmt_err), .done(done)
    );

    tagdec_parser #(.NUM_BYTES(NUM_BYTES)) u_parser (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pay_valid(pay_valid), .pay_byte(pay_byte),
        .val_valid(val_valid), .val_byte(val_byte), .val_idx(val_idx),
        .rec_tag(rec_tag), .rec_len(rec_len), .rec_end(rec_end),
        .num_valid(num_valid), .num_value(num_value)
    );

    AST_SILENT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!val_valid && !rec_end)); // R11
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R11

endmodule

// File: tb/tagdec_top_test.sv
module tagdec_top_test;

    logic        clk = 1'b0;
    logic        rst_n, start, in_valid;
    logic [7:0]  in_byte;
    logic        val_valid, rec_end, num_valid, crc_err, fmt_err, done;
    logic [7:0]  val_byte, val_idx, rec_tag, rec_len;
    logic [31:0] num_value;

    always #5 clk = ~clk;

    tagdec_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
        .val_valid(val_valid), .val_byte(val_byte), .val_idx(val_idx),
        .rec_tag(rec_tag), .rec_len(rec_len), .rec_end(rec_end),
        .num_valid(num_valid), .num_value(num_value),
        .crc_err(crc_err), .fmt_err(fmt_err), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  pay[$];
    logic [7:0]  stim[$];
    logic [31:0] exp_b[$];
    int          exp_bp[$];
    logic [63:0] exp_e[$];
    int          exp_ep[$];
    logic [31:0] obs_b[$];
    logic [63:0] obs_e[$];

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
            else                       r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: outputs are registered, sample at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (val_valid) obs_b.push_back({rec_tag, rec_len, val_idx, val_byte});
            if (rec_end)   obs_e.push_back({15'd0, rec_tag, rec_len, num_valid, num_value});
        end
    end

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected < 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Append one tag record to the payload and its expected events.
    task automatic add_tag(input logic [7:0] tg, input int ln, input bit fixed, input logic [31:0] dv);
        logic [31:0] num = '0;
        logic [7:0]  b;
        pay.push_back(tg);
        pay.push_back(ln[7:0]);
        for (int k = 0; k < ln; k++) begin
            b = (fixed && k < 4) ? dv[8*k +: 8] : 8'($urandom);
            pay.push_back(b);
            exp_b.push_back({tg, ln[7:0], k[7:0], b});
            exp_bp.push_back(pay.size() - 1);
            if (k < 4) num[8*k +: 8] = b;
        end
        exp_e.push_back({15'd0, tg, ln[7:0], (ln >= 1 && ln <= 4),
                         (ln >= 1 && ln <= 4) ? num : 32'd0});
        exp_ep.push_back(pay.size() - 1);
    endtask

    function automatic int rand_len();
        int r = int'($urandom % 8);
        if (r <= 4) return r;
        if (r == 5) return 5 + int'($urandom % 8);
        if (r == 6) return 13 + int'($urandom % 28);
        return 1;
    endfunction

    // Split payload into packets; corrupt check word of packet 'bad'.
    task automatic packetize(input int bad, input bit fixed, input int maxp, output int cut);
        int i = 0;
        int p = 0;
        int n;
        logic [15:0] c;
        cut = 1 << 30;
        while (i < pay.size()) begin
            n = fixed ? maxp : 1 + int'($urandom % maxp);
            if (n > pay.size() - i) n = pay.size() - i;
            stim.push_back(n[7:0]);
            c = crc_upd(16'h0, n[7:0]);
            for (int j = 0; j < n; j++) begin
                stim.push_back(pay[i+j]);
                c = crc_upd(c, pay[i+j]);
            end
            i += n;
            c = ~c;
            if (p == bad) begin
                c[0] = ~c[0];
                cut = i;
            end
            stim.push_back(c[7:0]);
            stim.push_back(c[15:8]);
            p++;
        end
    endtask

    task automatic send(input logic [7:0] b);
        repeat ($urandom % 3) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_case(input string nm, input int cut, input bit e_crc, input bit e_fmt);
        int nb = 0;
        int ne = 0;
        bit ok = 1'b1;
        repeat (2) @(negedge clk);
        obs_b.delete();
        obs_e.delete();
        pulse_start();
        foreach (stim[i]) send(stim[i]);
        for (int i = 0; i < 5; i++) send(8'($urandom));   // ignored after done
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R11", {nm, " done held"}, 64'(done), 64'd1);
        chk(crc_err == e_crc, "R3", {nm, " crc_err"}, 64'(crc_err), 64'(e_crc));
        chk(fmt_err == e_fmt, "R5", {nm, " fmt_err"}, 64'(fmt_err), 64'(e_fmt));
        foreach (exp_bp[i]) if (exp_bp[i] < cut) nb++;
        foreach (exp_ep[i]) if (exp_ep[i] < cut) ne++;
        chk(obs_b.size() == nb, "R6", {nm, " value byte count"}, 64'(obs_b.size()), 64'(nb));
        chk(obs_e.size() == ne, "R11", {nm, " record end count"}, 64'(obs_e.size()), 64'(ne));
        for (int i = 0; i < nb && i < obs_b.size(); i++) begin
            if (ok && obs_b[i] != exp_b[i]) begin
                chk(1'b0, "R7", {nm, " value byte stream"}, 64'(obs_b[i]), 64'(exp_b[i]));
                ok = 1'b0;
            end
        end
        if (ok) chk(1'b1, "R7", {nm, " value byte stream"}, 0, 0);
        for (int i = 0; i < ne && i < obs_e.size(); i++)
            chk(obs_e[i] == exp_e[i], (exp_e[i][40:33] > 8'd4) ? "R9" : "R8",
                {nm, " record end/number"}, obs_e[i], exp_e[i]);
        pay.delete(); stim.delete();
        exp_b.delete(); exp_bp.delete(); exp_e.delete(); exp_ep.delete();
    endtask

    initial begin
        int cut;
        int nt;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({val_valid, rec_end, num_valid, crc_err, fmt_err, done} == 6'd0, "R1",
            "flags after reset", 64'({val_valid, rec_end, num_valid, crc_err, fmt_err, done}), 0);
        chk({val_byte, val_idx, rec_tag, rec_len, num_value} == '0, "R1", "data after reset",
            64'(num_value), 0);

        // R7/R8/R4: seven-tag configuration on full pages, 00h terminator
        add_tag(8'd1, 35, 1'b0, 0);
        add_tag(8'd2, 4, 1'b1, 32'h3A1B_5C7D);
        add_tag(8'd3, 1, 1'b0, 0);
        add_tag(8'd4, 3, 1'b1, 32'h0008_0000);
        add_tag(8'd5, 1, 1'b0, 0);
        add_tag(8'd6, 1, 1'b0, 0);
        add_tag(8'd7, 1, 1'b0, 0);
        packetize(-1, 1'b1, 29, cut);
        stim.push_back(8'h00);
        run_case("R4 directed", cut, 1'b0, 1'b0);

        // R2/R6/R8/R9/R10: random records, packet sizes and gaps
        for (int s = 0; s < 6; s++) begin
            nt = 3 + int'($urandom % 8);
            for (int t = 1; t <= nt; t++) add_tag(t[7:0], rand_len(), 1'b0, 0);
            packetize(-1, 1'b0, 29, cut);
            stim.push_back((s % 2 == 0) ? 8'hFF : 8'h00);
            run_case("R2 random", cut, 1'b0, 1'b0);
        end

        // R3: corrupt the second packet's check word
        for (int t = 1; t <= 8; t++) add_tag(t[7:0], 1 + int'($urandom % 6), 1'b0, 0);
        packetize(1, 1'b1, 10, cut);
        stim.push_back(8'h00);
        run_case("R3 bad crc", cut, 1'b1, 1'b0);

        // R5: count just beyond a page, then far beyond
        for (int t = 1; t <= 4; t++) add_tag(t[7:0], rand_len(), 1'b0, 0);
        packetize(-1, 1'b0, 29, cut);
        stim.push_back(8'd30);
        stim.push_back(8'd5); stim.push_back(8'd1); stim.push_back(8'd2);
        run_case("R5 count 30", cut, 1'b0, 1'b1);
        for (int t = 1; t <= 3; t++) add_tag(t[7:0], rand_len(), 1'b0, 0);
        packetize(-1, 1'b0, 29, cut);
        stim.push_back(8'd200);
        run_case("R5 count 200", cut, 1'b0, 1'b1);

        // R10: abandon a decode mid-packet, then restart the full stream
        add_tag(8'd1, 20, 1'b0, 0);
        add_tag(8'd2, 2, 1'b0, 0);
        add_tag(8'd3, 40, 1'b0, 0);
        packetize(-1, 1'b1, 29, cut);
        stim.push_back(8'hFF);
        pulse_start();
        for (int i = 0; i < 17; i++) send(stim[i]);
        run_case("R10 restart", cut, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule